// File: doc/BRIEF.md
# Intel Hex Record Loader

This block takes a stream of ASCII characters, one byte per valid/ready transfer, that carries a program in Intel Hex form. It turns each pair of hex digits into a byte and walks through the fields of each record. It checks each record, then writes the data bytes one at a time to an on-chip RAM through a plain address, data and write-enable port. It keeps a segment base, which type 02H records set, and it reports the first address it loads as the program entry point.

Characters that arrive between records are dropped until the next ':' mark. The block fails permanently on any of these: a bad checksum, an unsupported record type, a non-hex character inside a record, or a data byte outside the load window. In that case it stops accepting input until reset.

When the end record arrives with a correct checksum, the block sends the 16-bit sum of all loaded bytes as two bytes, high byte first. It then raises `done` and takes no further input.

Top module: `ihex_loader`

## Requirements
- R1: Every character other than ':' (3AH) is dropped while the block waits for a record, both before the first record and after each checksum; it causes no write and no error.
- R2: Inside a record, each pair of characters from 0-9, A-F and a-f forms one byte, first character as the high nibble. Any other character inside a record, ':' included, sets `error`.
- R3: A record checks correctly when the count, both address bytes, the type, the data bytes and the checksum byte sum to 00H modulo 256. Otherwise `error` rises after the checksum byte, and it stays high with `in_ready` low until reset.
- R4: A type byte other than 00H (data), 01H (end) or 02H (segment) sets `error` as soon as the type byte completes.
- R5: After reset the segment base is 0, so a data record that has no segment record before it loads at its 16-bit offset.
- R6: A type 02H record sets a 16-bit segment value (first data byte high). Each later data byte goes to address segment*16 + record offset + byte index.
- R7: `entry_addr` holds the address of the first data byte written after reset, and `entry_valid` is high from that write onward.
- R8: Only addresses from 3000H to 57FFH (10240 bytes) are written. A data byte outside this window is not written and sets `error`.
- R9: After a correct end record, `out_valid` presents the upper byte of the sum and then the lower byte, each held until `out_ready`. `done` then stays high with `in_ready` low until reset.
- R10: The cycle after the clock edge that accepts the second digit of a data byte, `mem_we` pulses for one cycle with that byte's address and value.
- R11: After reset, `in_ready` is high and `mem_we`, `out_valid`, `done`, `error` and `entry_valid` are low.
- R12: The returned sum is the sum of all bytes written to the RAM, modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character available |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Block accepts a character this cycle |
| mem_we | output | 1 | RAM write strobe, one cycle per byte |
| mem_addr | output | AW (20) | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| out_valid | output | 1 | Sum byte available |
| out_data | output | 8 | Sum byte, upper first |
| out_ready | input | 1 | Consumer takes the sum byte |
| entry_addr | output | AW (20) | First loaded address |
| entry_valid | output | 1 | `entry_addr` is valid |
| done | output | 1 | Load finished and sum sent |
| error | output | 1 | Error idle state |

## Verification
A write is due in the cycle after the edge that accepts the second digit of a data byte. The bench drives each character for exactly one cycle and samples on the falling edge that follows, so a scoreboard monitor on that edge compares the write against the head of an expected queue. Error and state flags are registered on the edge that accepts the offending character, so the bench reads them on the falling edge right after the character's transfer. The first sum byte appears one cycle after the end record's checksum is accepted and the second byte one cycle later, with `out_ready` held high. A second queue checks both bytes, and `done` is read two cycles after that.

// File: rtl/ihex_loader.sv
module ihex_loader #(
  parameter int AW = 20,
  parameter logic [AW-1:0] WIN_BASE = 'h3000,
  parameter int WIN_SIZE = 10240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic [AW-1:0] entry_addr,
  output logic          entry_valid,
  output logic          done,
  output logic          error
);
  localparam logic [AW-1:0] WIN_END = WIN_BASE + AW'(WIN_SIZE);

  typedef enum logic [2:0] {S_HUNT, S_REC, S_OUT_HI, S_OUT_LO, S_DONE, S_ERR} state_t;
  state_t state;

  logic [3:0]    hi_nib, nib;
  logic          have_hi, is_hex, take;
  logic [8:0]    idx, data_i;
  logic [7:0]    len, rtype, chk, byte_in, chk_nx;
  logic [15:0]   off, seg, sum;
  logic [AW-1:0] wr_addr;
  logic          in_field, in_win;

  always_comb begin
    is_hex = 1'b1;
    nib    = 4'h0;
    if (in_data >= "0" && in_data <= "9")      nib = 4'(in_data - "0");
    else if (in_data >= "A" && in_data <= "F") nib = 4'(in_data - "A" + 8'd10);
    else if (in_data >= "a" && in_data <= "f") nib = 4'(in_data - "a" + 8'd10);
    else is_hex = 1'b0;
  end

  assign in_ready = (state == S_HUNT) || (state == S_REC);
  assign take     = in_valid && in_ready;
  assign byte_in  = {hi_nib, nib};
  assign chk_nx   = chk + byte_in;
  assign data_i   = idx - 9'd4;
  assign in_field = (idx >= 9'd4) && (data_i < {1'b0, len});
  assign wr_addr  = AW'({seg, 4'h0}) + AW'(off) + AW'(data_i);
  assign in_win   = (wr_addr >= WIN_BASE) && (wr_addr < WIN_END);

  assign out_valid = (state == S_OUT_HI) || (state == S_OUT_LO);
  assign out_data  = (state == S_OUT_HI) ? sum[15:8] : sum[7:0];
  assign done      = (state == S_DONE);
  assign error     = (state == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_HUNT;
      hi_nib      <= '0;
      have_hi     <= 1'b0;
      idx         <= '0;
      len         <= '0;
      rtype       <= '0;
      chk         <= '0;
      off         <= '0;
      seg         <= '0;
      sum         <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      entry_addr  <= '0;
      entry_valid <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        S_HUNT:
          if (take && in_data == 8'h3A) begin
            state   <= S_REC;
            idx     <= '0;
            have_hi <= 1'b0;
            chk     <= '0;
          end
        S_REC:
          if (take) begin
            if (!is_hex) state <= S_ERR;
            else if (!have_hi) begin
              hi_nib  <= nib;
              have_hi <= 1'b1;
            end else begin
              have_hi <= 1'b0;
              idx     <= idx + 9'd1;
              chk     <= chk_nx;
              case (idx)
                9'd0: len <= byte_in;
                9'd1: off[15:8] <= byte_in;
                9'd2: off[7:0] <= byte_in;
                9'd3: begin
                  rtype <= byte_in;
                  if (byte_in > 8'h02) state <= S_ERR;
                end
                default:
                  if (in_field) begin
                    if (rtype == 8'h00) begin
                      if (in_win) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wr_addr;
                        mem_wdata <= byte_in;
                        sum       <= sum + 16'(byte_in);
                        if (!entry_valid) begin
                          entry_addr  <= wr_addr;
                          entry_valid <= 1'b1;
                        end
                      end else state <= S_ERR;
                    end else if (rtype == 8'h02) begin
                      if (data_i == 9'd0) seg[15:8] <= byte_in;
                      else if (data_i == 9'd1) seg[7:0] <= byte_in;
                    end
                  end else if (chk_nx != 8'h00) state <= S_ERR;
                  else if (rtype == 8'h01) state <= S_OUT_HI;
                  else state <= S_HUNT;
              endcase
            end
          end
        S_OUT_HI: if (out_ready) state <= S_OUT_LO;
        S_OUT_LO: if (out_ready) state <= S_DONE;
        default: ;
      endcase
    end
  end

  a_r8_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= WIN_BASE && mem_addr < WIN_END));
  a_r10_write_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_ready));
  a_r3_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !in_ready && !mem_we);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !in_ready && !out_valid);
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r3_error_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(in_valid && in_ready));
  a_r7_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |=> entry_valid && $stable(entry_addr));
endmodule

// File: tb/sim_ihex_loader.sv
`timescale 1ns/1ps
module sim_ihex_loader;
  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, mem_we, out_valid, entry_valid, done, error;
  logic [19:0] mem_addr, entry_addr;
  logic [7:0] mem_wdata, out_data;

  ihex_loader u0 (.clk, .rst_n, .in_valid, .in_data, .in_ready, .mem_we, .mem_addr,
    .mem_wdata, .out_valid, .out_data, .out_ready, .entry_addr, .entry_valid, .done, .error);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [27:0] exp_wr[$];
  logic [7:0]  exp_out[$];
  logic [7:0]  pay[$];
  logic [15:0] exp_sum;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (exp_wr.size() == 0) check(0, "R10 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [27:0] e;
        e = exp_wr.pop_front();
        check({mem_addr, mem_wdata} == e, "R10 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
    if (out_valid && out_ready) begin
      if (exp_out.size() == 0) check(0, "R9 unexpected sum byte", out_data, 0);
      else begin
        logic [7:0] e;
        e = exp_out.pop_front();
        check(out_data == e, "R9/R12 sum byte", out_data, e);
      end
    end
  end

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
    if (n < 10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    if (in_ready) begin
      in_valid = 1; in_data = c;
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lower);
    send_char(hexc(b[7:4], lower));
    send_char(hexc(b[3:0], lower));
  endtask

  task automatic send_rec(input logic [15:0] addr, input logic [7:0] typ, input bit bad, input bit lower);
    logic [7:0] s;
    s = 8'(pay.size()) + addr[15:8] + addr[7:0] + typ;
    foreach (pay[i]) s += pay[i];
    send_char(8'h3A);
    send_byte(8'(pay.size()), lower);
    send_byte(addr[15:8], lower);
    send_byte(addr[7:0], lower);
    send_byte(typ, lower);
    foreach (pay[i]) send_byte(pay[i], lower);
    send_byte(8'(-s) + (bad ? 8'd1 : 8'd0), lower);
  endtask

  task automatic expect_data(input logic [19:0] base);
    foreach (pay[i]) begin
      exp_wr.push_back({base + 20'(i), pay[i]});
      exp_sum += 16'(pay[i]);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    check(exp_wr.size() == 0, "R10 all expected writes seen", exp_wr.size(), 0);
    exp_wr.delete(); exp_out.delete(); exp_sum = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_sum = 0;
    do_reset();
    // R11 reset state
    check(in_ready && !mem_we && !out_valid && !done && !error && !entry_valid, "R11 reset state",
          {in_ready, mem_we, out_valid, done, error, entry_valid}, 6'b100000);

    // R1 leading garbage ignored
    send_str("xy\r\n");
    check(!error && in_ready, "R1 garbage before first record", error, 0);

    // R5 data at offset with zero segment, uppercase
    pay = '{8'hAB, 8'h12};
    expect_data(20'h03000);
    send_rec(16'h3000, 8'h00, 0, 0);
    check(!error, "R3 good checksum", error, 0);
    check(entry_valid && entry_addr == 20'h03000, "R7 entry latched", entry_addr, 20'h03000);

    // R1 garbage between records
    send_str("zz 9\n");
    check(!error, "R1 garbage between records", error, 0);

    // R6 segment record then R2 lowercase data
    pay = '{8'h03, 8'h00};
    send_rec(16'h0000, 8'h02, 0, 0);
    pay = '{8'h5A, 8'hC3, 8'h01};
    expect_data(20'h03010);
    send_rec(16'h0010, 8'h00, 0, 1);
    check(!error, "R2 lowercase accepted", error, 0);
    check(entry_addr == 20'h03000, "R7 entry keeps first address", entry_addr, 20'h03000);

    // R9 end record
    exp_out.push_back(exp_sum[15:8]);
    exp_out.push_back(exp_sum[7:0]);
    pay = {};
    send_rec(16'h0000, 8'h01, 0, 0);
    repeat (3) @(negedge clk);
    check(exp_out.size() == 0, "R9 two sum bytes sent", exp_out.size(), 0);
    check(done && !in_ready && !error, "R9 done held", {done, in_ready, error}, 3'b100);
    send_str(":00");
    check(done && !in_ready, "R9 no input after done", {done, in_ready}, 2'b10);

    // R5 after reset, no segment record
    do_reset();
    pay = '{8'h77};
    expect_data(20'h03100);
    send_rec(16'h3100, 8'h00, 0, 0);
    check(entry_addr == 20'h03100 && entry_valid, "R5 offset-only address", entry_addr, 20'h03100);
    // R3 bad checksum
    pay = '{8'h11};
    expect_data(20'h03200);
    send_rec(16'h3200, 8'h00, 1, 0);
    check(error && !in_ready, "R3 checksum error", {error, in_ready}, 2'b10);
    repeat (4) @(negedge clk);
    check(error, "R3 error held", error, 1);

    // R4 unsupported type
    do_reset();
    pay = '{8'h01};
    send_rec(16'h3000, 8'h03, 0, 0);
    check(error, "R4 bad record type", error, 1);

    // R2 non-hex inside a record
    do_reset();
    send_str(":0G");
    check(error, "R2 non-hex in record", error, 1);

    // R8 upper window edge
    do_reset();
    pay = '{8'h02, 8'h03};
    exp_wr.push_back({20'h057FF, 8'h02});
    send_rec(16'h57FF, 8'h00, 0, 0);
    check(error, "R8 write past window end", error, 1);

    // R8 below window
    do_reset();
    pay = '{8'h09};
    send_rec(16'h2FFF, 8'h00, 0, 0);
    check(error && !entry_valid, "R8 write below window", {error, entry_valid}, 2'b10);

    // R12 sum over several records
    do_reset();
    pay = '{8'hFF, 8'hFF, 8'hFF};
    expect_data(20'h04000);
    send_rec(16'h4000, 8'h00, 0, 0);
    pay = '{8'h80};
    expect_data(20'h05000);
    send_rec(16'h5000, 8'h00, 0, 0);
    exp_out.push_back(exp_sum[15:8]);
    exp_out.push_back(exp_sum[7:0]);
    pay = {};
    send_rec(16'h0000, 8'h01, 0, 0);
    repeat (3) @(negedge clk);
    check(done && exp_out.size() == 0, "R12 sum returned", exp_out.size(), 0);

    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule